// File: doc/BRIEF.md
# Sync Polarity and Presence Monitor

This block watches the horizontal and vertical sync lines of a display source. For each line it works out which level the sync pulses take, whether pulses are still arriving, and, while a line has gone quiet, the static level it rests at. On the horizontal line it measures the time between pulses in reference-clock cycles. The count saturates, and an overflow flag shows the saturated state. Both lines pass through a two-flop synchroniser before any edge is detected.

Six sticky change flags record events. There is one flag each for a change of presence, of polarity and of measured period, for each line. Each flag has an enable bit, and the interrupt line is high whenever an enabled flag is set. Software clears a flag by writing a one to it. A slow time-base tick sets the time allowed without an edge before a line is declared absent.

Top module: `sync_pol_monitor`

## Requirements
- R1: While reset is high, and at the first sample after reset is applied, `status`, `hcnt_hi`, `hcnt_lo`, `h_ovf`, `flags`, `irq_en` and `irq` are all zero.
- R2: `status[0]` (horizontal) and `status[1]` (vertical) read 1 when the time the line spends high in a period is shorter than the time it spends low, meaning positive pulses. They read 0 otherwise.
- R3: `status[2]` (horizontal) and `status[3]` (vertical) drop to 0 once TMO_TICKS (default 4) `tick` pulses pass with no edge on the line. They return to 1 on the next edge.
- R4: While a line is absent, `status[4]` (horizontal) and `status[5]` (vertical) give the line's static level.
- R5: `{hcnt_hi, hcnt_lo}` holds the number of clocks between the last two active horizontal edges. `hcnt_hi` carries bits 10:8 and `hcnt_lo` bits 7:0. The active edge is rising when the polarity bit is 1 and falling when it is 0. The first active edge after presence returns only restarts the measurement.
- R6: The period count saturates at 2047. `h_ovf` is 1 while the running horizontal counter sits at 2047, and it clears after the next active edge.
- R7: `flags[4]` (horizontal) and `flags[5]` (vertical) are set when two successive measured periods differ by more than FRQ_TOL (default 2) clocks. A difference of FRQ_TOL or less sets nothing.
- R8: `flags[0]` and `flags[1]` are set when the horizontal or vertical presence bit changes. `flags[2]` and `flags[3]` are set when the horizontal or vertical polarity bit changes.
- R9: A cycle with `clr_wr` high clears every flag whose bit in `clr_wdata` is 1 and leaves the bits written 0 unchanged. If an event arrives in the same cycle as a clear, the event wins.
- R10: `irq_en` loads `en_wdata` in a cycle with `en_wr` high. `irq` is 1 exactly when some bit of `flags & irq_en` is 1, and it changes on the same clock edge as the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| tick | input | 1 | One-cycle time-base pulse |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | New enable bits |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_wdata | input | 6 | Flags to clear (1 clears) |
| status | output | 6 | {v_idle, h_idle, v_pres, h_pres, v_pol, h_pol} |
| hcnt_hi | output | CNT_W-8 | High bits of horizontal period count |
| hcnt_lo | output | 8 | Low bits of horizontal period count |
| h_ovf | output | 1 | Horizontal counter saturated |
| flags | output | 6 | {v_frq, h_frq, v_pol, h_pol, v_pres, h_pres} change flags |
| irq_en | output | 6 | Flag enable bits |
| irq | output | 1 | Interrupt request |

## Verification
An edge on a sync input reaches `status`, `h_ovf` and the period count three clock edges later: two in the synchroniser and one in the channel register. The change flags and `irq` follow on the fourth edge. A register write is seen on the first edge after its strobe. The driver waits far longer than these latencies after every change of stimulus, by hundreds of cycles or by whole sync periods. Only then does it push the expected value into the scoreboard queue, and the monitor compares it at the next falling clock edge. Where a transition can legitimately set other bits, the queued item carries a mask, so that only the bits the requirement fixes are compared.

// File: rtl/smon_pkg.sv
`timescale 1ns/1ps
package smon_pkg;
  localparam int NUM_SYNC = 2;
  localparam int NUM_EVT  = 3 * NUM_SYNC;
  localparam int CH_H     = 0;
  localparam int CH_V     = 1;

  // event kinds; the flag index is kind * NUM_SYNC + channel
  typedef enum logic [1:0] {
    EV_PRES = 2'd0,
    EV_POL  = 2'd1,
    EV_FRQ  = 2'd2
  } evt_kind_e;
endpackage

// File: rtl/smon_sync2.sv
`timescale 1ns/1ps
module smon_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/smon_chan.sv
`timescale 1ns/1ps
module smon_chan #(
  parameter int CNT_W     = 11,
  parameter int TMO_TICKS = 4,
  parameter int FRQ_TOL   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_in,
  input  logic             tick,
  output logic             pol_o,
  output logic             pres_o,
  output logic             idle_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             ev_pres_o,
  output logic             ev_pol_o,
  output logic             ev_frq_o
);
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOL   = CNT_W'(FRQ_TOL);
  localparam int               TW    = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;
  localparam logic [TW-1:0]    TLAST = TW'(TMO_TICKS - 1);

  logic             s_d, rise, fall, any_edge, act;
  logic [CNT_W-1:0] hi_cnt, lo_cnt, hi_len, lo_len;
  logic [CNT_W-1:0] per, per_n, diff;
  logic [TW-1:0]    tmo;
  logic             pol_n, pres_n, armed, vld;

  assign rise     = s_in & ~s_d;
  assign fall     = ~s_in & s_d;
  assign any_edge = rise | fall;
  assign pol_n    = (hi_len < lo_len);
  assign act      = pol_o ? rise : fall;
  assign diff     = (per > cnt_o) ? (per - cnt_o) : (cnt_o - per);

  always_comb begin
    pres_n = pres_o;
    if (any_edge)
      pres_n = 1'b1;
    else if (tick && pres_o && (tmo == TLAST))
      pres_n = 1'b0;
  end

  always_comb begin
    if (act)
      per_n = CONE;
    else if (per == CMAX)
      per_n = CMAX;
    else
      per_n = per + CONE;
  end

  // phase length measurement and polarity
  always_ff @(posedge clk) begin
    if (rst) begin
      s_d      <= 1'b0;
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      hi_len   <= '0;
      lo_len   <= '0;
      pol_o    <= 1'b0;
      ev_pol_o <= 1'b0;
    end else begin
      s_d <= s_in;
      if (fall) begin
        hi_len <= hi_cnt;
        hi_cnt <= '0;
      end else if (s_in && hi_cnt != CMAX) begin
        hi_cnt <= hi_cnt + CONE;
      end
      if (rise) begin
        lo_len <= lo_cnt;
        lo_cnt <= '0;
      end else if (!s_in && lo_cnt != CMAX) begin
        lo_cnt <= lo_cnt + CONE;
      end
      pol_o    <= pol_n;
      ev_pol_o <= pol_n ^ pol_o;
    end
  end

  // presence timeout and idle level
  always_ff @(posedge clk) begin
    if (rst) begin
      pres_o    <= 1'b0;
      ev_pres_o <= 1'b0;
      tmo       <= '0;
      idle_o    <= 1'b0;
    end else begin
      pres_o    <= pres_n;
      ev_pres_o <= pres_n ^ pres_o;
      if (any_edge)
        tmo <= '0;
      else if (tick && pres_o && tmo != TLAST)
        tmo <= tmo + 1'b1;
      if (!pres_n)
        idle_o <= s_in;
    end
  end

  // period measurement, overflow and change detection
  always_ff @(posedge clk) begin
    if (rst) begin
      per      <= '0;
      cnt_o    <= '0;
      ovf_o    <= 1'b0;
      armed    <= 1'b0;
      vld      <= 1'b0;
      ev_frq_o <= 1'b0;
    end else begin
      per      <= per_n;
      ovf_o    <= (per_n == CMAX);
      ev_frq_o <= 1'b0;
      if (!pres_n) begin
        armed <= 1'b0;
        vld   <= 1'b0;
      end else if (act) begin
        armed <= 1'b1;
        if (armed) begin
          cnt_o    <= per;
          vld      <= 1'b1;
          ev_frq_o <= vld && (diff > TOL);
        end
      end
    end
  end

  assert_pres_drop_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pres_o) |-> $past(tick));
  assert_pres_back_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pres_o) |-> $past(any_edge));
  assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_o) |-> $past(act));
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(act) |-> $stable(cnt_o));
endmodule

// File: rtl/smon_irq.sv
`timescale 1ns/1ps
module smon_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_wdata,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] clr_mask, flags_n, en_n;

  assign clr_mask = clr_wr ? clr_wdata : '0;
  assign flags_n  = (flags_o & ~clr_mask) | evt;
  assign en_n     = en_wr ? en_wdata : en_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      en_o    <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= flags_n;
      en_o    <= en_n;
      irq_o   <= |(flags_n & en_n);
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags_o & $past(evt)) == $past(evt)));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (($past(flags_o) & ~$past(clr_mask) & ~flags_o) == '0));
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(|evt) || $past(en_wr)));
endmodule

// File: rtl/sync_pol_monitor.sv
`timescale 1ns/1ps
module sync_pol_monitor
  import smon_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int TMO_TICKS = 4,
  parameter int FRQ_TOL   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               tick,
  input  logic               en_wr,
  input  logic [NUM_EVT-1:0] en_wdata,
  input  logic               clr_wr,
  input  logic [NUM_EVT-1:0] clr_wdata,
  output logic [NUM_EVT-1:0] status,
  output logic [CNT_W-9:0]   hcnt_hi,
  output logic [7:0]         hcnt_lo,
  output logic               h_ovf,
  output logic [NUM_EVT-1:0] flags,
  output logic [NUM_EVT-1:0] irq_en,
  output logic               irq
);
  logic [NUM_SYNC-1:0] s_sync;
  logic [NUM_SYNC-1:0] ch_pol, ch_pres, ch_idle, ch_ovf;
  logic [NUM_SYNC-1:0] ev_pres, ev_pol, ev_frq;
  logic [CNT_W-1:0]    ch_cnt [NUM_SYNC];
  logic [NUM_EVT-1:0]  evt;

  smon_sync2 #(.W(NUM_SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({vsync_in, hsync_in}),
    .q   (s_sync)
  );

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_chan
    localparam int B_PRES = int'(EV_PRES) * NUM_SYNC + i;
    localparam int B_POL  = int'(EV_POL)  * NUM_SYNC + i;
    localparam int B_FRQ  = int'(EV_FRQ)  * NUM_SYNC + i;

    smon_chan #(
      .CNT_W     (CNT_W),
      .TMO_TICKS (TMO_TICKS),
      .FRQ_TOL   (FRQ_TOL)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .s_in      (s_sync[i]),
      .tick      (tick),
      .pol_o     (ch_pol[i]),
      .pres_o    (ch_pres[i]),
      .idle_o    (ch_idle[i]),
      .cnt_o     (ch_cnt[i]),
      .ovf_o     (ch_ovf[i]),
      .ev_pres_o (ev_pres[i]),
      .ev_pol_o  (ev_pol[i]),
      .ev_frq_o  (ev_frq[i])
    );

    assign evt[B_PRES] = ev_pres[i];
    assign evt[B_POL]  = ev_pol[i];
    assign evt[B_FRQ]  = ev_frq[i];

    assert_ovf_rise_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_ovf[i]) |-> $stable(ch_cnt[i]));
  end

  smon_irq #(.N(NUM_EVT)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .clr_wr    (clr_wr),
    .clr_wdata (clr_wdata),
    .flags_o   (flags),
    .en_o      (irq_en),
    .irq_o     (irq)
  );

  assign status  = {ch_idle, ch_pres, ch_pol};
  assign hcnt_hi = ch_cnt[CH_H][CNT_W-1:8];
  assign hcnt_lo = ch_cnt[CH_H][7:0];
  assign h_ovf   = ch_ovf[CH_H];
endmodule

// File: tb/sync_pol_monitor_tb.sv
`timescale 1ns/1ps
module sync_pol_monitor_tb;
  localparam int CNT_W = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic hsync_in = 1'b0, vsync_in = 1'b0, tick = 1'b0;
  logic en_wr = 1'b0, clr_wr = 1'b0;
  logic [5:0] en_wdata = '0, clr_wdata = '0;
  logic [5:0] status, flags, irq_en;
  logic [CNT_W-9:0] hcnt_hi;
  logic [7:0] hcnt_lo;
  logic h_ovf, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int   h_period = 40, h_width = 4, v_period = 200, v_width = 10, tick_div = 64;
  logic h_pos = 1'b1, h_run = 1'b0, h_idle = 1'b0;
  logic v_pos = 1'b1, v_run = 1'b0;

  sync_pol_monitor #(.CNT_W(CNT_W), .TMO_TICKS(4), .FRQ_TOL(2)) u_dut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in), .tick(tick),
    .en_wr(en_wr), .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .status(status), .hcnt_hi(hcnt_hi), .hcnt_lo(hcnt_lo), .h_ovf(h_ovf),
    .flags(flags), .irq_en(irq_en), .irq(irq)
  );

  always #5 clk = ~clk;

  // time-base tick
  initial begin
    forever begin
      repeat (tick_div - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // horizontal generator: whole periods, settings sampled per period
  initial begin
    int p, w;
    logic lv;
    forever begin
      if (h_run) begin
        p = h_period; w = h_width; lv = h_pos;
        for (int i = 0; i < p; i++) begin
          @(negedge clk);
          hsync_in = (i < w) ? lv : !lv;
        end
      end else begin
        @(negedge clk);
        hsync_in = h_idle;
      end
    end
  end

  // vertical generator
  initial begin
    int p, w;
    logic lv;
    forever begin
      if (v_run) begin
        p = v_period; w = v_width; lv = v_pos;
        for (int i = 0; i < p; i++) begin
          @(negedge clk);
          vsync_in = (i < w) ? lv : !lv;
        end
      end else begin
        @(negedge clk);
        vsync_in = 1'b0;
      end
    end
  end

  // scoreboard
  int    q_sel[$], q_exp[$], q_msk[$];
  string q_tag[$];

  function automatic int pick(int sel);
    case (sel)
      0: return int'(status);
      1: return int'({hcnt_hi, hcnt_lo});
      2: return int'(h_ovf);
      3: return int'(flags);
      4: return int'(irq);
      default: return int'(irq_en);
    endcase
  endfunction

  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      int s, e, m, a;
      string t;
      s = q_sel.pop_front(); e = q_exp.pop_front();
      m = q_msk.pop_front(); t = q_tag.pop_front();
      a = pick(s);
      checks++;
      if ((a & m) != (e & m)) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h (mask %0h)", t, a & m, e & m, m);
      end
    end
  end

  task automatic expect_val(int sel, int exp, int msk, string tag);
    q_sel.push_back(sel); q_exp.push_back(exp);
    q_msk.push_back(msk); q_tag.push_back(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(logic [5:0] v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wr_clr(logic [5:0] v);
    @(negedge clk); clr_wr = 1'b1; clr_wdata = v;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    expect_val(0, 0, 'h3f, "R1 status in reset");
    expect_val(1, 0, 'h7ff, "R1 count in reset");
    expect_val(2, 0, 1, "R1 ovf in reset");
    expect_val(3, 0, 'h3f, "R1 flags in reset");
    expect_val(4, 0, 1, "R1 irq in reset");
    expect_val(5, 0, 'h3f, "R1 enables in reset");
    rst = 1'b0;

    // positive pulses on both lines
    h_run = 1'b1; v_run = 1'b1;
    wait_cyc(3000);
    expect_val(0, 'h0f, 'h3f, "R2 R3 both positive and present");
    expect_val(1, 40, 'h7ff, "R5 period 40");
    expect_val(2, 0, 1, "R6 no overflow at period 40");
    wr_clr(6'h3f);
    expect_val(3, 0, 'h3f, "R9 all flags cleared");

    // within tolerance
    h_period = 41; wait_cyc(300);
    expect_val(1, 41, 'h7ff, "R5 period 41");
    expect_val(3, 0, 'h3f, "R7 diff 1 sets no flag");
    h_period = 43; wait_cyc(300);
    expect_val(1, 43, 'h7ff, "R5 period 43");
    expect_val(3, 0, 'h3f, "R7 diff 2 equals tolerance, no flag");
    h_period = 47; wait_cyc(300);
    expect_val(1, 47, 'h7ff, "R5 period 47");
    expect_val(3, 'h10, 'h3f, "R7 diff 4 sets h freq flag only");
    expect_val(4, 0, 1, "R10 no irq with enables clear");
    wr_en(6'h10);
    expect_val(5, 'h10, 'h3f, "R10 enable register loaded");
    expect_val(4, 1, 1, "R10 irq with enabled flag");
    wr_clr(6'h01);
    expect_val(3, 'h10, 'h3f, "R9 clearing unset bit leaves others");
    wr_clr(6'h10);
    expect_val(3, 0, 'h3f, "R9 h freq flag cleared");
    expect_val(4, 0, 1, "R10 irq drops after clear");

    // horizontal turns negative
    h_pos = 1'b0; wait_cyc(600);
    expect_val(0, 'h0e, 'h0f, "R2 h negative, v positive");
    expect_val(3, 'h04, 'h2f, "R8 h polarity change flag");
    expect_val(1, 47, 'h7ff, "R5 period 47 on falling edges");
    wr_en(6'h04);
    expect_val(4, 1, 1, "R10 irq from polarity flag");
    wr_en(6'h00);
    wr_clr(6'h3f);

    // horizontal stops high
    h_run = 1'b0; h_idle = 1'b1;
    wait_cyc(1000);
    expect_val(0, 'h18, 'h3c, "R3 R4 h absent, idle high");
    expect_val(3, 'h01, 'h03, "R8 h presence change flag");
    wait_cyc(1500);
    expect_val(2, 1, 1, "R6 overflow while counter saturated");
    h_idle = 1'b0;
    wait_cyc(1000);
    expect_val(0, 'h08, 'h3c, "R4 h absent, idle low");

    // horizontal returns
    wr_clr(6'h3f);
    h_pos = 1'b1; h_period = 40; h_run = 1'b1;
    wait_cyc(600);
    expect_val(0, 'h0c, 'h3c, "R3 h present again");
    expect_val(2, 0, 1, "R6 overflow cleared after active edges");
    expect_val(1, 40, 'h7ff, "R5 period 40 after return");
    expect_val(3, 0, 'h20, "R7 no v freq flag on steady v");

    // long period keeps presence with slow tick, count saturates
    tick_div = 1000; h_period = 2500;
    wait_cyc(9000);
    expect_val(1, 2047, 'h7ff, "R6 latched count saturates at 2047");
    expect_val(0, 'h04, 'h04, "R3 h still present with slow tick");

    wait_cyc(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule